// File: doc/BRIEF.md
# Alias-Operation Control Register Bank

This block is a bank of 32-bit control registers on a simple single-cycle memory-mapped bus. Each register owns a 16-byte address slot. Address bits [3:2] of a write pick one of four aliases inside that slot:

- A plain store replaces the register.
- A set alias ORs the write data into the register.
- A clear alias removes every bit that is 1 in the write data.
- A toggle alias XORs the write data into the register.

Software can therefore change single bits without a read-modify-write sequence. A read through any of the four aliases returns the stored value.

A request is presented for one cycle with address, write enable, a full-word qualifier and write data. Writes take effect on the clock edge that accepts them. Read data is combinational from the request and is valid in the same cycle. The number of registers, the address width and the per-register reset values are parameters. Reset is synchronous and active high.

Top module: `alias_op_regbank`

## Requirements
- R1: On a clock edge with `rst` high, every register loads its slice of `RESET_VALS`. Register i takes bits [32*i+31:32*i]. A register whose slice is zero resets to zero.
- R2: An accepted write with address bits [3:0] = 0x0 replaces the selected register with `req_wdata`.
- R3: An accepted write with address bits [3:0] = 0x4 ORs `req_wdata` into the selected register.
- R4: An accepted write with address bits [3:0] = 0x8 clears each register bit that is 1 in `req_wdata` and keeps the others.
- R5: An accepted write with address bits [3:0] = 0xC XORs `req_wdata` into the selected register.
- R6: The register index is address bits [ADDR_W-1:4]. A read (`req_valid`=1, `req_write`=0, full aligned word) at any of the four aliases of a register returns that register's value on `req_rdata` in the same cycle.
- R7: A write updates the register on the edge that accepts it. A read in the next cycle returns the new value, including when writes to the same register come back to back.
- R8: A write to a register index of `NUM_REGS` or above changes no register. A read there returns zero.
- R9: An access with `req_word`=0, or with address bits [1:0] not 00, is not a register operation. As a write it changes no register; as a read it returns zero.
- R10: With `req_valid` low, no register changes and `req_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = full 32-bit access |
| req_addr | input | ADDR_W | Byte address: slot index in [ADDR_W-1:4], alias in [3:2] |
| req_wdata | input | DATA_W | Write data, used as a bit mask by the set, clear and toggle aliases |
| req_rdata | output | DATA_W | Read data, zero unless a valid aligned read hits a register |

## Verification
The bench runs each alias on values where OR, AND-NOT, XOR and store give different results. A design that decodes the alias bits wrongly, or inverts the mask for clear, reads back a wrong word. It reads every register through aliases other than the one that wrote it, which catches a decoder that uses bits [3:2] in the index. It aims writes just past the last register, at unaligned and narrow addresses, and with the valid signal low, then reads the neighbouring registers: a missing guard shows up as corruption or as non-zero read data. It also issues back-to-back writes, and asserts reset mid-run after changing the non-zero reset registers, so a stale update or a reset that only zeroes is caught.

// File: rtl/alias_op_regbank.sv
module alias_op_regbank #(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS =
    {{(NUM_REGS-3)*DATA_W{1'b0}}, 32'h1234_5678, 32'h0000_A5A5, 32'h0000_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] req_rdata
);
  localparam int IDX_W = ADDR_W - 4;
  localparam logic [IDX_W:0] NREG = (IDX_W+1)'(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic [1:0]       op;
  logic             hit;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;

  assign idx = req_addr[ADDR_W-1:4];
  assign op  = req_addr[3:2];
  assign hit = req_valid && req_word && (req_addr[1:0] == 2'b00) && ({1'b0, idx} < NREG);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= RESET_VALS[i*DATA_W +: DATA_W];
      else if (hit && req_write && idx == IDX_W'(i))
        case (op)
          2'd0: q <= req_wdata;
          2'd1: q <= q | req_wdata;
          2'd2: q <= q & ~req_wdata;
          default: q <= q ^ req_wdata;
        endcase
    end
    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end

  always_comb begin
    req_rdata = '0;
    if (hit && !req_write)
      for (int i = 0; i < NUM_REGS; i++)
        if (idx == IDX_W'(i)) req_rdata = regs_flat[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/alias_op_regbank_sva.sv
module alias_op_regbank_sva #(
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [NUM_REGS*DATA_W-1:0] RESET_VALS = '0
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic                       req_write,
  input logic                       req_word,
  input logic [ADDR_W-1:0]          req_addr,
  input logic [DATA_W-1:0]          req_wdata,
  input logic [DATA_W-1:0]          req_rdata,
  input logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam int IDX_W = ADDR_W - 4;

  function automatic logic [DATA_W-1:0] pick(input logic [NUM_REGS*DATA_W-1:0] v, input logic [IDX_W-1:0] k);
    pick = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (k == IDX_W'(i)) pick = v[i*DATA_W +: DATA_W];
  endfunction

  logic [IDX_W-1:0] c_idx;
  logic c_in, c_al, c_wr;
  assign c_idx = req_addr[ADDR_W-1:4];
  assign c_in  = 32'(c_idx) < NUM_REGS;
  assign c_al  = req_word && req_addr[1:0] == 2'b00;
  assign c_wr  = req_valid && req_write && c_in && c_al;

  logic [1:0]        l_op;
  logic              l_wr;
  logic [IDX_W-1:0]  l_idx;
  logic [DATA_W-1:0] l_data, l_old;
  always_ff @(posedge clk) begin
    if (rst) begin
      l_wr <= 1'b0; l_op <= '0; l_idx <= '0; l_data <= '0; l_old <= '0;
    end else begin
      l_wr   <= c_wr;
      l_op   <= req_addr[3:2];
      l_idx  <= c_idx;
      l_data <= req_wdata;
      l_old  <= pick(regs_flat, c_idx);
    end
  end

  a_r1_reset_load: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> regs_flat == RESET_VALS);
  a_r2_store:      assert property (@(posedge clk) disable iff (rst) (l_wr && l_op == 2'd0) |-> pick(regs_flat, l_idx) == l_data);
  a_r3_set:        assert property (@(posedge clk) disable iff (rst) (l_wr && l_op == 2'd1) |-> pick(regs_flat, l_idx) == (l_old | l_data));
  a_r4_clear:      assert property (@(posedge clk) disable iff (rst) (l_wr && l_op == 2'd2) |-> pick(regs_flat, l_idx) == (l_old & ~l_data));
  a_r5_toggle:     assert property (@(posedge clk) disable iff (rst) (l_wr && l_op == 2'd3) |-> pick(regs_flat, l_idx) == (l_old ^ l_data));
  a_r6_read_alias: assert property (@(posedge clk) disable iff (rst) (req_valid && !req_write && c_in && c_al) |-> req_rdata == pick(regs_flat, c_idx));
  a_r8_oor_read:   assert property (@(posedge clk) disable iff (rst) (req_valid && !c_in) |-> req_rdata == '0);
  a_r8_oor_write:  assert property (@(posedge clk) disable iff (rst) (req_valid && !c_in) |=> $stable(regs_flat));
  a_r9_narrow:     assert property (@(posedge clk) disable iff (rst) (req_valid && !c_al) |=> $stable(regs_flat));
  a_r9_narrow_rd:  assert property (@(posedge clk) disable iff (rst) (req_valid && !c_al) |-> req_rdata == '0);
  a_r10_idle:      assert property (@(posedge clk) disable iff (rst) !req_valid |=> $stable(regs_flat));
endmodule

bind alias_op_regbank alias_op_regbank_sva #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_VALS(RESET_VALS)
) i_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
  .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata), .regs_flat(regs_flat)
);

// File: tb/test_alias_op_regbank.sv
module test_alias_op_regbank;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_word;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata, req_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alias_op_regbank i_alias_op_regbank (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata)
  );

  // {write, tag, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 4'd1, 8'h10, 32'h0, 32'h0000_A5A5},   // R1 reset value reg1
    {1'b0, 4'd1, 8'h00, 32'h0, 32'h0000_0000},   // R1 zero default reg0
    {1'b0, 4'd1, 8'h28, 32'h0, 32'h1234_5678},   // R1 reg2 via clear alias, R6
    {1'b1, 4'd2, 8'h00, 32'hDEAD_BEEF, 32'h0},   // R2 store
    {1'b0, 4'd2, 8'h04, 32'h0, 32'hDEAD_BEEF},   // R2 read via set alias, R6
    {1'b1, 4'd3, 8'h04, 32'h0000_00F0, 32'h0},   // R3 set
    {1'b0, 4'd3, 8'h08, 32'h0, 32'hDEAD_BEFF},
    {1'b1, 4'd4, 8'h08, 32'hFFFF_0000, 32'h0},   // R4 clear
    {1'b0, 4'd4, 8'h0C, 32'h0, 32'h0000_BEFF},
    {1'b1, 4'd5, 8'h0C, 32'h0000_FFFF, 32'h0},   // R5 toggle
    {1'b0, 4'd5, 8'h00, 32'h0, 32'h0000_4100},
    {1'b1, 4'd5, 8'h1C, 32'h0000_FFFF, 32'h0},   // R5 toggle reg1
    {1'b0, 4'd5, 8'h14, 32'h0, 32'h0000_5A5A},
    {1'b1, 4'd8, 8'h60, 32'hFFFF_FFFF, 32'h0},   // R8 write past last reg
    {1'b0, 4'd8, 8'h60, 32'h0, 32'h0000_0000},   // R8 read past last reg
    {1'b0, 4'd8, 8'h50, 32'h0, 32'h0000_0000},   // R8 last reg untouched
    {1'b1, 4'd9, 8'h25, 32'hFFFF_FFFF, 32'h0},   // R9 unaligned write
    {1'b0, 4'd9, 8'h20, 32'h0, 32'h1234_5678},
    {1'b1, 4'd6, 8'h58, 32'h0000_0000, 32'h0},   // R6 clear on zero reg5
    {1'b0, 4'd6, 8'h5C, 32'h0, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic word = 1'b1, input logic vld = 1'b1);
    @(negedge clk);
    req_valid = vld; req_write = 1'b1; req_word = word; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_word = 1'b1;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp, input logic word = 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_word = word; req_addr = a; req_wdata = '0;
    #1 chk(req, req_rdata, exp);
    req_valid = 1'b0; req_word = 1'b1;
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_word = 1; req_addr = '0; req_wdata = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][71:64], VEC[i][63:32]);
      else rd($sformatf("R%0d vec%0d", VEC[i][75:72], i), VEC[i][71:64], VEC[i][31:0]);
    end

    // R9 narrow write ignored, narrow read gives zero
    wr(8'h10, 32'hFFFF_FFFF, 1'b0);
    rd("R9 narrow write", 8'h10, 32'h0000_5A5A);
    rd("R9 narrow read", 8'h10, 32'h0, 1'b0);

    // R10 valid low: no update, rdata zero
    wr(8'h20, 32'h0, 1'b1, 1'b0);
    rd("R10 idle write", 8'h20, 32'h1234_5678);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = 8'h20;
    #1 chk("R10 idle rdata", req_rdata, 32'h0);

    // R7 back-to-back writes to one register
    @(negedge clk);
    req_valid = 1; req_write = 1; req_word = 1; req_addr = 8'h34; req_wdata = 32'h0000_0F0F;
    @(negedge clk);
    req_addr = 8'h38; req_wdata = 32'h0000_0303;
    @(negedge clk);
    req_addr = 8'h3C; req_wdata = 32'h0000_00FF;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    rd("R7 back-to-back", 8'h30, 32'h0000_0CF3);

    // R7 write then immediate read
    wr(8'h40, 32'hCAFE_0001);
    rd("R7 next-cycle read", 8'h4C, 32'hCAFE_0001);

    // R1 reset mid-run restores values
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rd("R1 mid reset reg0", 8'h00, 32'h0);
    rd("R1 mid reset reg1", 8'h10, 32'h0000_A5A5);
    rd("R1 mid reset reg4", 8'h40, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule